// File: doc/BRIEF.md
# Profiling Control Register Access Gate

This block decides what happens when software tries to read or write one of the profiling control registers. It looks at the exception level of the request, whether it is a read or a write, and a set of configuration inputs. These inputs describe the monitor level, the hypervisor level, fine-grained trapping, a coarse profiling trap, the ownership of the profiling buffer and the current security state. It then picks exactly one of four outcomes: the access is allowed, it raises an undefined-instruction exception, it traps to the hypervisor level, or it traps to the monitor level.

The decision is purely combinational and follows a fixed priority order. The ownership test comes first, but only when the undefined-priority flag is set. The hypervisor traps (fine-grained, then coarse) come next. The ordinary ownership test is last, and it either undefines or routes to the monitor. Level 0 is always refused and level 3 is always allowed. At level 2 the hypervisor traps are skipped. Instruction decode happens upstream; the gate only sees a request strobe with its level and direction.

Top module: `sysreg_access_gate`

## Requirements
- R1: With `req_valid` low, all four outcome outputs are 0 and `out_class` is 0.
- R2: A request from level 0 (`req_el`=0) gives `out_undef`, whatever the configuration.
- R3: A request from level 3 (`req_el`=3) gives `out_allow`, whatever the configuration.
- R4: The buffer is foreign when any of these holds: `own_bits[0]` is 0; `own_bits[1]` differs from `sec_ns`; or `realm_present` is 1 and `own_ext` differs from `sec_nse`.
- R5: At level 1 or 2, a present monitor with `undef_prio_flag` set and a foreign buffer gives `out_undef`. This check outranks every hypervisor trap.
- R6: At level 1, the fine-grained trap to the hypervisor fires when all of these hold: `hyp_enabled`, `fgt_present`, (no monitor or `fgt_enable`=1), and the direction's trap bit. That bit is `fgt_rd_trap` when `req_write`=0 and `fgt_wr_trap` when `req_write`=1.
- R7: At level 1, `hyp_enabled` together with `coarse_trap` gives `out_trap_hyp`.
- R8: When no earlier check fires, a present monitor with a foreign buffer gives `out_undef` if `undef_sdd_flag` is 1, and `out_trap_mon` otherwise.
- R9: At level 2 the hypervisor traps are never taken. Only the checks of R5 and R8 apply, in that order.
- R10: `out_class` is 0x18 whenever either trap output is high, and 0 otherwise.
- R11: While `req_valid` is high, exactly one outcome output is high. If no check fires, that output is `out_allow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | An access request is present |
| req_el | input | 2 | Exception level of the request, 0 to 3 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| mon_present | input | 1 | Monitor level is implemented |
| hyp_enabled | input | 1 | Hypervisor level is enabled for the current state |
| fgt_present | input | 1 | Fine-grained trap feature is implemented |
| fgt_enable | input | 1 | Monitor's enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fgt_wr_trap | input | 1 | Fine-grained trap bit for writes |
| coarse_trap | input | 1 | Coarse profiling trap bit in the hypervisor |
| own_bits | input | 2 | Buffer owner: bit 0 non-secure owned, bit 1 owner security state |
| own_ext | input | 1 | Buffer owner extended-security bit |
| sec_ns | input | 1 | Current non-secure bit |
| sec_nse | input | 1 | Current extended-security bit |
| realm_present | input | 1 | Realm extension is implemented |
| undef_prio_flag | input | 1 | Ownership undefined takes priority over hypervisor traps |
| undef_sdd_flag | input | 1 | Ownership failure undefines instead of trapping to the monitor |
| out_allow | output | 1 | Access proceeds |
| out_undef | output | 1 | Undefined-instruction exception |
| out_trap_hyp | output | 1 | Trap to the hypervisor level |
| out_trap_mon | output | 1 | Trap to the monitor level |
| out_class | output | 6 | Syndrome class of a trap, 0 when no trap |

## Verification
All five results (the four outcome lines and the class code) depend only on the present inputs, so they are due in the same cycle as the stimulus, with zero register stages. The bench changes the inputs on the falling clock edge and reads the outputs one nanosecond later, well before the next rising edge, so every sample sees settled values from the current vector only. Fixed table rows cover each priority crossing, and a randomized sweep is compared against a bench-side model of the rules.

// File: rtl/sra_pkg.sv
package sra_pkg;
  // bit positions inside the one-hot outcome vector
  localparam int OUT_ALLOW = 0;
  localparam int OUT_UNDEF = 1;
  localparam int OUT_HYP   = 2;
  localparam int OUT_MON   = 3;
  localparam int OUT_N     = 4;

  localparam int CLASS_W   = 6;

  typedef logic [OUT_N-1:0] outcome_t;

  // buffer-owner mismatch against the current security state
  function automatic logic foreign_owner(input logic [1:0] own,
                                         input logic own_x,
                                         input logic ns,
                                         input logic nse,
                                         input logic realm);
    logic mismatch_ns;
    logic mismatch_x;
    mismatch_ns = (own[1] != ns);
    mismatch_x  = realm && (own_x != nse);
    return !own[0] || mismatch_ns || mismatch_x;
  endfunction

  // single-bit outcome vector from a bit index
  function automatic outcome_t pick(input int idx);
    outcome_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sra_owner_check.sv
module sra_owner_check
  import sra_pkg::*;
(
  input  logic       mon_present,
  input  logic [1:0] own_bits,
  input  logic       own_ext,
  input  logic       sec_ns,
  input  logic       sec_nse,
  input  logic       realm_present,
  input  logic       undef_prio_flag,
  output logic       foreign,
  output logic       prio_undef_hit,
  output logic       own_hit
);
  always_comb begin
    foreign        = foreign_owner(own_bits, own_ext, sec_ns, sec_nse, realm_present);
    own_hit        = mon_present && foreign;
    prio_undef_hit = own_hit && undef_prio_flag;
  end
endmodule

// File: rtl/sra_hyp_trap.sv
module sra_hyp_trap (
  input  logic hyp_enabled,
  input  logic fgt_present,
  input  logic fgt_enable,
  input  logic mon_present,
  input  logic fgt_rd_trap,
  input  logic fgt_wr_trap,
  input  logic coarse_trap,
  input  logic is_write,
  output logic fg_hit,
  output logic coarse_hit
);
  logic dir_bit;
  logic fg_allowed;

  always_comb begin
    dir_bit    = is_write ? fgt_wr_trap : fgt_rd_trap;
    fg_allowed = hyp_enabled && fgt_present && (!mon_present || fgt_enable);
    fg_hit     = fg_allowed && dir_bit;
    coarse_hit = hyp_enabled && coarse_trap;
  end
endmodule

// File: rtl/sra_resolve.sv
module sra_resolve
  import sra_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_el,
  input  logic       prio_undef_hit,
  input  logic       fg_hit,
  input  logic       coarse_hit,
  input  logic       own_hit,
  input  logic       undef_sdd_flag,
  output outcome_t   outcome
);
  logic     hyp_path;
  outcome_t tail;

  always_comb begin
    // level 1 may reach the hypervisor checks; level 2 may not
    hyp_path = (req_el == 2'd1) && (fg_hit || coarse_hit);
    if (own_hit) tail = undef_sdd_flag ? pick(OUT_UNDEF) : pick(OUT_MON);
    else         tail = pick(OUT_ALLOW);

    outcome = '0;
    if (req_valid) begin
      unique case (req_el)
        2'd0: outcome = pick(OUT_UNDEF);
        2'd3: outcome = pick(OUT_ALLOW);
        default: begin
          if (prio_undef_hit) outcome = pick(OUT_UNDEF);
          else if (hyp_path)  outcome = pick(OUT_HYP);
          else                outcome = tail;
        end
      endcase
    end
  end
endmodule

// File: rtl/sysreg_access_gate.sv
module sysreg_access_gate
  import sra_pkg::*;
#(
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               req_valid,
  input  logic [1:0]         req_el,
  input  logic               req_write,
  input  logic               mon_present,
  input  logic               hyp_enabled,
  input  logic               fgt_present,
  input  logic               fgt_enable,
  input  logic               fgt_rd_trap,
  input  logic               fgt_wr_trap,
  input  logic               coarse_trap,
  input  logic [1:0]         own_bits,
  input  logic               own_ext,
  input  logic               sec_ns,
  input  logic               sec_nse,
  input  logic               realm_present,
  input  logic               undef_prio_flag,
  input  logic               undef_sdd_flag,
  output logic               out_allow,
  output logic               out_undef,
  output logic               out_trap_hyp,
  output logic               out_trap_mon,
  output logic [CLASS_W-1:0] out_class
);
  logic     foreign;
  logic     prio_undef_hit;
  logic     own_hit;
  logic     fg_hit;
  logic     coarse_hit;
  outcome_t outcome;

  sra_owner_check u_own (
    .mon_present    (mon_present),
    .own_bits       (own_bits),
    .own_ext        (own_ext),
    .sec_ns         (sec_ns),
    .sec_nse        (sec_nse),
    .realm_present  (realm_present),
    .undef_prio_flag(undef_prio_flag),
    .foreign        (foreign),
    .prio_undef_hit (prio_undef_hit),
    .own_hit        (own_hit)
  );

  sra_hyp_trap u_hyp (
    .hyp_enabled(hyp_enabled),
    .fgt_present(fgt_present),
    .fgt_enable (fgt_enable),
    .mon_present(mon_present),
    .fgt_rd_trap(fgt_rd_trap),
    .fgt_wr_trap(fgt_wr_trap),
    .coarse_trap(coarse_trap),
    .is_write   (req_write),
    .fg_hit     (fg_hit),
    .coarse_hit (coarse_hit)
  );

  sra_resolve u_res (
    .req_valid     (req_valid),
    .req_el        (req_el),
    .prio_undef_hit(prio_undef_hit),
    .fg_hit        (fg_hit),
    .coarse_hit    (coarse_hit),
    .own_hit       (own_hit),
    .undef_sdd_flag(undef_sdd_flag),
    .outcome       (outcome)
  );

  always_comb begin
    out_allow    = outcome[OUT_ALLOW];
    out_undef    = outcome[OUT_UNDEF];
    out_trap_hyp = outcome[OUT_HYP];
    out_trap_mon = outcome[OUT_MON];
    out_class    = (outcome[OUT_HYP] || outcome[OUT_MON]) ? TRAP_CLASS : '0;
  end

  // checks on the outputs against the submodule event wires
  always_comb begin
    if (!req_valid) begin
      a_r1_idle: assert ({out_allow, out_undef, out_trap_hyp, out_trap_mon} == 4'b0 && out_class == '0)
        else $error("R1 outputs active without a request");
    end else begin
      a_r11_one_hot: assert ($countones({out_allow, out_undef, out_trap_hyp, out_trap_mon}) == 1)
        else $error("R11 outcome not one-hot");
      if (req_el == 2'd0) begin
        a_r2_el0_undef: assert (out_undef)
          else $error("R2 level 0 not undefined");
      end
      if (req_el == 2'd3) begin
        a_r3_el3_allow: assert (out_allow)
          else $error("R3 level 3 not allowed");
      end
      if (req_el != 2'd0 && req_el != 2'd3 && prio_undef_hit) begin
        a_r5_prio_undef: assert (out_undef)
          else $error("R5 priority undefined not taken");
      end
      if (req_el == 2'd2) begin
        a_r9_el2_no_hyp: assert (!out_trap_hyp)
          else $error("R9 hypervisor trap at level 2");
      end
      if (out_trap_mon) begin
        a_r8_mon_needs_owner: assert (own_hit && foreign && !undef_sdd_flag)
          else $error("R8 monitor trap without ownership failure");
      end
    end
    a_r10_class: assert ((out_trap_hyp || out_trap_mon) ? (out_class == TRAP_CLASS) : (out_class == '0))
      else $error("R10 class code mismatch");
  end
endmodule

// File: tb/sim_sysreg_access_gate.sv
module sim_sysreg_access_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid, req_el_w, req_write;
  logic [1:0] req_el;
  logic       mon_present, hyp_enabled, fgt_present, fgt_enable;
  logic       fgt_rd_trap, fgt_wr_trap, coarse_trap;
  logic [1:0] own_bits;
  logic       own_ext, sec_ns, sec_nse, realm_present, undef_prio_flag, undef_sdd_flag;
  logic       out_allow, out_undef, out_trap_hyp, out_trap_mon;
  logic [5:0] out_class;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sysreg_access_gate u0 (
    .req_valid(req_valid), .req_el(req_el), .req_write(req_write),
    .mon_present(mon_present), .hyp_enabled(hyp_enabled),
    .fgt_present(fgt_present), .fgt_enable(fgt_enable),
    .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap),
    .coarse_trap(coarse_trap), .own_bits(own_bits), .own_ext(own_ext),
    .sec_ns(sec_ns), .sec_nse(sec_nse), .realm_present(realm_present),
    .undef_prio_flag(undef_prio_flag), .undef_sdd_flag(undef_sdd_flag),
    .out_allow(out_allow), .out_undef(out_undef), .out_trap_hyp(out_trap_hyp),
    .out_trap_mon(out_trap_mon), .out_class(out_class)
  );

  // expected codes: {monitor, hypervisor, undefined, allow}
  localparam logic [3:0] A = 4'b0001, U = 4'b0010, H = 4'b0100, M = 4'b1000;

  typedef struct packed {
    logic [1:0] el;
    logic wr, mon, hyp, fgtp, fgte, fgtr, fgtw, coarse;
    logic [1:0] own;
    logic ownx, ns, nse, realm, uprio, usdd;
    logic [3:0] exp;
    logic [3:0] rq;
  } vec_t;

  // clean owner: own=11, ns=1; foreign owner: own=10
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, U, 4'd2},  // R2
    '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b10,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, U, 4'd2},  // R2
    '{2'd3,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b10,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, A, 4'd3},  // R3
    '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, A, 4'd11}, // R11
    '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, H, 4'd6},  // R6 read bit
    '{2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, A, 4'd6},  // R6 write ignores read bit
    '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, A, 4'd6},  // R6 monitor, no enable
    '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, H, 4'd6},  // R6 monitor, enabled
    '{2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, H, 4'd7},  // R7
    '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, A, 4'd7},  // R7 no hypervisor
    '{2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, U, 4'd5},  // R5
    '{2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, H, 4'd8},  // R8 hyp outranks
    '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, M, 4'd8},  // R8 monitor
    '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, U, 4'd8},  // R8 undefined
    '{2'd2,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b10,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, M, 4'd9},  // R9
    '{2'd2,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, A, 4'd9},  // R9
    '{2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, M, 4'd4},  // R4 ns mismatch
    '{2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, M, 4'd4},  // R4 realm mismatch
    '{2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, A, 4'd4},  // R4 realm absent
    '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, A, 4'd11}  // R11 no monitor
  };

  task automatic apply(input vec_t v, input logic valid);
    req_valid = valid; req_el = v.el; req_write = v.wr;
    mon_present = v.mon; hyp_enabled = v.hyp; fgt_present = v.fgtp;
    fgt_enable = v.fgte; fgt_rd_trap = v.fgtr; fgt_wr_trap = v.fgtw;
    coarse_trap = v.coarse; own_bits = v.own; own_ext = v.ownx;
    sec_ns = v.ns; sec_nse = v.nse; realm_present = v.realm;
    undef_prio_flag = v.uprio; undef_sdd_flag = v.usdd;
  endtask

  // requirement model, written as a decision list over the rules
  function automatic logic [3:0] model(input vec_t v);
    logic bad_owner, mon_fail, hyp_trap, dir;
    bad_owner = (v.own[0] == 1'b0) || (v.own[1] ^ v.ns) || (v.realm && (v.ownx ^ v.nse));
    mon_fail  = v.mon & bad_owner;
    dir       = v.wr ? v.fgtw : v.fgtr;
    hyp_trap  = (v.hyp & v.fgtp & (~v.mon | v.fgte) & dir) | (v.hyp & v.coarse);
    if (v.el == 2'd0) return U;
    if (v.el == 2'd3) return A;
    if (mon_fail && v.uprio) return U;
    if (v.el == 2'd1 && hyp_trap) return H;
    if (mon_fail) return v.usdd ? U : M;
    return A;
  endfunction

  task automatic check(input logic [3:0] exp, input int rq, input string what);
    logic [3:0] got;
    logic [5:0] ecls;
    got  = {out_trap_mon, out_trap_hyp, out_undef, out_allow};
    ecls = (exp == H || exp == M) ? 6'h18 : 6'h00;
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: outcome %b expected %b", rq, what, got, exp);
    end
    checks++;
    if (out_class !== ecls) begin
      errors++;
      $display("FAIL R10 %s: class %h expected %h", what, out_class, ecls);
    end
  endtask

  initial begin
    vec_t v;
    v = '0;
    apply(v, 1'b0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, even with trap inputs raised
    @(negedge clk);
    v = TBL[1]; apply(v, 1'b0);
    #1 check(4'b0000, 1, "idle with traps configured");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i], 1'b1);
      #1 check(TBL[i].exp, int'(TBL[i].rq), $sformatf("table row %0d", i));
    end

    // R1: dropping the request clears everything
    @(negedge clk);
    apply(TBL[12], 1'b0);
    #1 check(4'b0000, 1, "request dropped");

    // R11 and R10 over a random sweep against the model
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      v = vec_t'({$urandom, $urandom});
      v.exp = model(v);
      apply(v, 1'b1);
      #1 check(v.exp, 11, $sformatf("sweep %0d", k));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // spare wire kept driven to avoid an undriven net
  assign req_el_w = req_el[0];
endmodule